// File: doc/BRIEF.md
# Router Port Counting Bloom Invalidation Filter

This block sits beside one output port of a mesh router and keeps an approximate record of which cache-line addresses may be held by caches reachable through that port. The record is a table of small saturating counters indexed by a hash of the line address. Header flits of cache-miss requests heading toward the home directory raise the counter for their line. Header flits of writebacks and invalidation acknowledgements heading back to the directory lower it.

When an invalidation header is about to leave through the port, the block looks up its counter. A non-zero counter means some downstream cache might hold a line with that hash, so the invalidation is forwarded. A zero counter means no downstream cache can hold such a line. In that case the invalidation is dropped and the router spawns an acknowledgement back to the directory in its place.

The table may give false positives but never false negatives. Routing, virtual channels and flit storage are handled elsewhere. The router presents one update strobe and one check strobe per cycle, each with a header flag, a packet type and an address.

Top module: `bloom_port_filter`

## Requirements
- R1: After reset every counter is zero and all three outputs are low, so the first invalidation checked spawns an acknowledgement.
- R2: A valid header on the update channel with type 1 (miss request) increments the counter at its hashed index; a later invalidation to that address is forwarded.
- R3: A valid update header of type 2 (writeback) or type 3 (invalidation ack) decrements the counter at its hashed index; once the counter is back at zero, an invalidation to that index is dropped and an acknowledgement is spawned.
- R4: A check-channel strobe with valid and header set and type 4 (invalidation) raises exactly one of `inv_fwd_o` (counter non-zero) or `ack_spawn_o` (counter zero) on the following cycle; in any other cycle both stay low.
- R5: Non-header flits, and packet types other than those named in R2 to R4 (types 0, 5, 6, 7), change no counter and raise no output.
- R6: The index is the XOR of successive 6-bit slices of address bits [31:6] (the top slice zero-padded); the low 6 offset bits are ignored, so addresses within one line share a counter, and a different line with the same index is forwarded as a false positive.
- R7: A counter at its maximum (7) stays there on further increments and is never decremented again until reset.
- R8: A decrement aimed at a zero counter leaves it at zero and pulses `dec_err_o` for one cycle on the following cycle.
- R9: When an update and a check hit the same index in the same cycle, the check sees the counter value after that update.
- R10: All outputs are registered and report on the cycle after the strobe that caused them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_valid_i | input | 1 | Update channel flit present |
| upd_head_i | input | 1 | Update flit is a header |
| upd_type_i | input | 3 | Update packet type |
| upd_addr_i | input | 32 | Update packet byte address |
| chk_valid_i | input | 1 | Check channel flit present |
| chk_head_i | input | 1 | Check flit is a header |
| chk_type_i | input | 3 | Check packet type |
| chk_addr_i | input | 32 | Check packet byte address |
| inv_fwd_o | output | 1 | Invalidation must be forwarded |
| ack_spawn_o | output | 1 | Invalidation dropped, spawn acknowledgement |
| dec_err_o | output | 1 | Decrement hit a zero counter |

## Verification
The assertions take for granted that the router sends at most one update and one check per cycle. They also assume type codes arrive stable for the whole cycle and that reset is held long enough to reach every counter. The stimulus drives both channels only on falling edges, one strobe per channel per cycle. It reaches underflow only by sending one more acknowledgement than there were misses. It uses hand-chosen addresses whose indices follow from R6 without any help from the design.

// File: rtl/bloom_filter_pkg.sv
package bloom_filter_pkg;

    typedef enum logic [2:0] {
        PK_OTHER    = 3'd0,
        PK_MISS_REQ = 3'd1,
        PK_WBACK    = 3'd2,
        PK_INV_ACK  = 3'd3,
        PK_INVAL    = 3'd4
    } pkt_e;

    typedef struct packed {
        logic fwd;
        logic spawn;
        logic err;
    } filt_out_t;

endpackage

// File: rtl/bloom_xor_fold.sv
module bloom_xor_fold #(
    parameter int ADDR_W   = 32,
    parameter int OFFSET_W = 6,
    parameter int IDX_W    = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int LINE_W = ADDR_W - OFFSET_W;
    localparam int NSLICE = (LINE_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = NSLICE * IDX_W;

    logic [PAD_W-1:0] padded;

    always_comb begin
        padded = '0;
        padded[LINE_W-1:0] = addr_i[ADDR_W-1:OFFSET_W];
        idx_o = '0;
        for (int s = 0; s < NSLICE; s++) begin
            idx_o = idx_o ^ padded[s*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/bloom_counter_bank.sv
module bloom_counter_bank #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 3,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic [IDX_W-1:0] upd_idx_i,
    input  logic [IDX_W-1:0] chk_idx_i,
    output logic             chk_hit_o,
    output logic             underflow_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [DEPTH];
    logic [CNT_W-1:0] cnt_d [DEPTH];
    logic [CNT_W-1:0] cur;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            cnt_d[i] = cnt_q[i];
        end
        cur = cnt_q[upd_idx_i];
        underflow_o = dec_i && (cur == '0);
        if (inc_i && cur != CNT_MAX) begin
            cnt_d[upd_idx_i] = cur + 1'b1;
        end else if (dec_i && cur != '0 && cur != CNT_MAX) begin
            cnt_d[upd_idx_i] = cur - 1'b1;
        end
        // update-first: the check reads the post-update value
        chk_hit_o = (cnt_d[chk_idx_i] != '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) begin
                cnt_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                cnt_q[i] <= cnt_d[i];
            end
        end
    end

    // R7: saturated counter is sticky
    p_sat_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q[upd_idx_i] == CNT_MAX) |=> (cnt_q[$past(upd_idx_i)] == CNT_MAX));

    // R8: decrement of a zero counter does not wrap
    p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_i && !inc_i && cnt_q[upd_idx_i] == '0) |=> (cnt_q[$past(upd_idx_i)] == '0));

    // R2: increment below saturation adds exactly one
    p_inc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && cnt_q[upd_idx_i] != CNT_MAX)
        |=> (cnt_q[$past(upd_idx_i)] == $past(cnt_q[upd_idx_i]) + 1'b1));
endmodule

// File: rtl/bloom_port_filter.sv
module bloom_port_filter
    import bloom_filter_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFFSET_W = 6,
    parameter int DEPTH    = 64,
    parameter int CNT_W    = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              upd_valid_i,
    input  logic              upd_head_i,
    input  logic [2:0]        upd_type_i,
    input  logic [ADDR_W-1:0] upd_addr_i,
    input  logic              chk_valid_i,
    input  logic              chk_head_i,
    input  logic [2:0]        chk_type_i,
    input  logic [ADDR_W-1:0] chk_addr_i,
    output logic              inv_fwd_o,
    output logic              ack_spawn_o,
    output logic              dec_err_o
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0] upd_idx, chk_idx;
    logic             upd_fire, chk_fire, inc, dec, hit, underflow;
    filt_out_t        out_d, out_q;

    bloom_xor_fold #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .IDX_W(IDX_W)) i_upd_hash (
        .addr_i(upd_addr_i), .idx_o(upd_idx));

    bloom_xor_fold #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .IDX_W(IDX_W)) i_chk_hash (
        .addr_i(chk_addr_i), .idx_o(chk_idx));

    assign upd_fire = upd_valid_i && upd_head_i;
    assign chk_fire = chk_valid_i && chk_head_i && (chk_type_i == PK_INVAL);
    assign inc      = upd_fire && (upd_type_i == PK_MISS_REQ);
    assign dec      = upd_fire && (upd_type_i == PK_WBACK || upd_type_i == PK_INV_ACK);

    bloom_counter_bank #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .inc_i      (inc),
        .dec_i      (dec),
        .upd_idx_i  (upd_idx),
        .chk_idx_i  (chk_idx),
        .chk_hit_o  (hit),
        .underflow_o(underflow)
    );

    always_comb begin
        out_d       = '0;
        out_d.fwd   = chk_fire && hit;
        out_d.spawn = chk_fire && !hit;
        out_d.err   = underflow;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign inv_fwd_o   = out_q.fwd;
    assign ack_spawn_o = out_q.spawn;
    assign dec_err_o   = out_q.err;

    // R4: exactly one outcome per checked invalidation
    p_one_outcome_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_fire |=> (inv_fwd_o ^ ack_spawn_o));

    // R4, R5: silent when nothing is checked
    p_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !chk_fire |=> (!inv_fwd_o && !ack_spawn_o));

    // R8: error only follows a decrement strobe
    p_err_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dec |=> !dec_err_o);
endmodule

// File: tb/test_bloom_port_filter.sv
module test_bloom_port_filter;

    typedef struct packed {
        logic        uv;
        logic        uh;
        logic [2:0]  ut;
        logic [31:0] ua;
        logic        cv;
        logic        ch;
        logic [2:0]  ct;
        logic [31:0] ca;
        logic        ef;
        logic        es;
        logic        ee;
    } vec_t;

    // A idx1, A_AL idx1 (other line), B idx2
    localparam logic [31:0] A    = 32'h0000_1000;
    localparam logic [31:0] A_OF = 32'h0000_103F;
    localparam logic [31:0] A_AL = 32'h0000_0040;
    localparam logic [31:0] B    = 32'h0000_0080;
    localparam logic [31:0] C    = 32'h0000_00C0;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,3'd0,32'h0, 1'b1,1'b1,3'd4,A,    1'b0,1'b1,1'b0}, // R1 empty table
        '{1'b1,1'b1,3'd1,A,     1'b0,1'b0,3'd0,32'h0,1'b0,1'b0,1'b0}, // R2 miss A
        '{1'b0,1'b0,3'd0,32'h0, 1'b1,1'b1,3'd4,A,    1'b1,1'b0,1'b0}, // R2 forward
        '{1'b0,1'b0,3'd0,32'h0, 1'b1,1'b1,3'd4,A_AL, 1'b1,1'b0,1'b0}, // R6 alias
        '{1'b0,1'b0,3'd0,32'h0, 1'b1,1'b1,3'd4,A_OF, 1'b1,1'b0,1'b0}, // R6 offset
        '{1'b0,1'b0,3'd0,32'h0, 1'b1,1'b1,3'd4,B,    1'b0,1'b1,1'b0}, // R4 miss
        '{1'b1,1'b0,3'd2,A,     1'b0,1'b0,3'd0,32'h0,1'b0,1'b0,1'b0}, // R5 body flit
        '{1'b1,1'b1,3'd0,B,     1'b1,1'b1,3'd4,B,    1'b0,1'b1,1'b0}, // R5 other type
        '{1'b1,1'b1,3'd2,A,     1'b1,1'b1,3'd4,A,    1'b0,1'b1,1'b0}, // R3 R9 wback
        '{1'b1,1'b1,3'd1,B,     1'b1,1'b1,3'd4,B,    1'b1,1'b0,1'b0}, // R9 inc first
        '{1'b1,1'b1,3'd3,B,     1'b1,1'b1,3'd4,B,    1'b0,1'b1,1'b0}, // R3 inv ack
        '{1'b1,1'b1,3'd3,B,     1'b0,1'b0,3'd0,32'h0,1'b0,1'b0,1'b1}, // R8 underflow
        '{1'b0,1'b0,3'd0,32'h0, 1'b1,1'b1,3'd4,B,    1'b0,1'b1,1'b0}, // R8 no wrap
        '{1'b0,1'b0,3'd0,32'h0, 1'b1,1'b0,3'd4,A,    1'b0,1'b0,1'b0}, // R5 body check
        '{1'b0,1'b0,3'd0,32'h0, 1'b1,1'b1,3'd1,A,    1'b0,1'b0,1'b0}  // R5 non-inval
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uv = 1'b0, uh = 1'b0, cv = 1'b0, ch = 1'b0;
    logic [2:0]  ut = '0, ct = '0;
    logic [31:0] ua = '0, ca = '0;
    logic        fwd, spawn, err;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    bloom_port_filter i_bloom_port_filter (
        .clk_i(clk), .rst_ni(rst_n),
        .upd_valid_i(uv), .upd_head_i(uh), .upd_type_i(ut), .upd_addr_i(ua),
        .chk_valid_i(cv), .chk_head_i(ch), .chk_type_i(ct), .chk_addr_i(ca),
        .inv_fwd_o(fwd), .ack_spawn_o(spawn), .dec_err_o(err)
    );

    task automatic compare(input string req, input logic ef, es, ee);
        n_chk++;
        if ({fwd, spawn, err} !== {ef, es, ee}) begin
            n_bad++;
            $display("FAIL %s: fwd/spawn/err got %b%b%b expected %b%b%b",
                     req, fwd, spawn, err, ef, es, ee);
        end
    endtask

    task automatic step(input logic iuv, iuh, input logic [2:0] iut, input logic [31:0] iua,
                        input logic icv, ich, input logic [2:0] ict, input logic [31:0] ica);
        @(negedge clk);
        uv = iuv; uh = iuh; ut = iut; ua = iua;
        cv = icv; ch = ich; ct = ict; ca = ica;
        @(posedge clk);
        #2;
        uv = 1'b0; cv = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        compare("R1 reset", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].uv, VEC[i].uh, VEC[i].ut, VEC[i].ua,
                 VEC[i].cv, VEC[i].ch, VEC[i].ct, VEC[i].ca);
            compare($sformatf("vector %0d", i), VEC[i].ef, VEC[i].es, VEC[i].ee);
        end

        // R7: saturate C with 9 misses, then 8 writebacks, counter stays set
        for (int i = 0; i < 9; i++) step(1'b1, 1'b1, 3'd1, C, 1'b0, 1'b0, 3'd0, 32'h0);
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b1, 3'd2, C, 1'b0, 1'b0, 3'd0, 32'h0);
            compare("R7 no err on saturated decrement", 1'b0, 1'b0, 1'b0);
        end
        step(1'b0, 1'b0, 3'd0, 32'h0, 1'b1, 1'b1, 3'd4, C);
        compare("R7 sticky saturation", 1'b1, 1'b0, 1'b0);

        // R10: output lasts one cycle only
        step(1'b0, 1'b0, 3'd0, 32'h0, 1'b0, 1'b0, 3'd0, 32'h0);
        compare("R10 single-cycle pulse", 1'b0, 1'b0, 1'b0);

        // R1: reset clears table mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        compare("R1 outputs low in reset", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 3'd0, 32'h0, 1'b1, 1'b1, 3'd4, C);
        compare("R1 table cleared", 1'b0, 1'b1, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule